// File: doc/BRIEF.md
# Double-Buffered Transmit Slot Controller

This block sits between a software-facing register interface and a byte-serial transmitter. Software describes each outgoing frame with a buffer address and a byte length. The block keeps at most two descriptors: the one being sent now (the active slot) and the one queued behind it (the pending slot). While a frame is active, the block reads its bytes one per cycle from a fetch port and presents them on a byte stream. When the frame finishes, a waiting descriptor moves up to the active slot on the next clock edge. Because of this, two back-to-back frames leave the block with no idle gap between them.

Software learns the block's state from a small status vector. Two bits are live levels: room for another descriptor, and activity. The other bits are sticky event flags: overrun, idle, complete and underrun. A register write that arrives while both slots are full is dropped and raises the overrun flag. If the fetch side fails to deliver a byte when one is needed, the frame is cut short. The block then emits an end marker with a bad-CRC sideband, so that the downstream CRC stage corrupts the frame check sequence.

Top module: `tx_slot_ctrl`

## Requirements
- R1: After reset the status vector reads 7'h01 (room bit 0 set, all else clear), and tx_valid, tx_last, tx_bad_crc and fetch_rd are low.
- R2: A write with reg_wr_sel=0 only stages an address, and no frame starts. A write with reg_wr_sel=1 and a nonzero length commits the staged address and that length as a descriptor. The frame then appears as bytes read from address, address+1, ... address+length-1, one per cycle, with tx_last on the final byte.
- R3: Status bit 0 (room) is clear exactly when both the active and the pending slot hold a descriptor. Status bit 1 (busy) is set while the active slot holds one.
- R4: A write to either register while room is clear sets status bit 2 (overrun). The write is dropped and leaves the staged address, the active descriptor and the pending descriptor unchanged.
- R5: When the active frame ends, a pending descriptor becomes active on the next edge. Its first byte follows the previous frame's last byte in the very next cycle.
- R6: A frame that ends normally sets status bit 5 (complete).
- R7: If fetch_ready is low in a cycle in which a byte is needed, the frame is aborted. On the next cycle the block outputs tx_last=1, tx_bad_crc=1 and tx_valid=0. Status bit 6 (underrun) is set and bit 5 is not.
- R8: Status bit 3 (idle) is set when a frame ends with no pending descriptor and no commit in the same cycle.
- R9: Writing a one in sts_clr_data under sts_clr_wr clears the matching sticky bit among bits 2, 3, 5 and 6. A set event in the same cycle wins over the clear. Bits 0, 1 and 4 are not affected by such a write.
- R10: A commit with length zero is dropped. It occupies no slot and sends nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_sel | input | 1 | 0 = stage address, 1 = commit with length |
| reg_wr_data | input | AW (32) | Address, or length in the low LW bits |
| sts_clr_wr | input | 1 | Write-one-to-clear strobe for status |
| sts_clr_data | input | 7 | Clear mask |
| sts_flags | output | 7 | Status vector |
| fetch_rd | output | 1 | A byte is needed this cycle |
| fetch_addr | output | AW (32) | Byte address requested |
| fetch_data | input | 8 | Byte returned in the same cycle |
| fetch_ready | input | 1 | fetch_data is valid this cycle |
| tx_valid | output | 1 | tx_byte carries frame data |
| tx_byte | output | 8 | Frame byte |
| tx_last | output | 1 | Frame end (last byte or abort marker) |
| tx_bad_crc | output | 1 | Abort marker: downstream must spoil the CRC |

## Verification
Two pairs of events are made to land in the same cycle, and the bench checks how each pair resolves. First, a length write that commits a new descriptor is timed to coincide exactly with the final byte fetch of the active frame. The bench expects the new frame to take the active slot directly, to start on the very next cycle, and to leave the idle flag clear. Second, an overrun write is issued together with a clear of the overrun flag, and the flag must read set afterwards. In each case, the byte positions and the start cycle of each recorded frame are compared with addresses the bench computes itself.

// File: rtl/tx_slot_pkg.sv
package tx_slot_pkg;
    localparam int STS_W   = 7;
    localparam int ST_ROOM = 0;
    localparam int ST_BUSY = 1;
    localparam int ST_OVR  = 2;
    localparam int ST_IDLE = 3;
    localparam int ST_CMPL = 5;
    localparam int ST_UNDR = 6;
    localparam logic [STS_W-1:0] STICKY_MASK =
        STS_W'((1 << ST_OVR) | (1 << ST_IDLE) | (1 << ST_CMPL) | (1 << ST_UNDR));
endpackage

// File: rtl/tx_slot_queue.sv
module tx_slot_queue #(
    parameter int AW = 32,
    parameter int LW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          wr_sel,
    input  logic [AW-1:0] wr_data,
    input  logic          frame_end,
    output logic          act_valid,
    output logic [AW-1:0] act_addr,
    output logic [LW-1:0] act_len,
    output logic          room,
    output logic          ovr_evt,
    output logic          idle_evt
);
    typedef struct packed {
        logic [AW-1:0] stage_addr;
        logic          act_v;
        logic [AW-1:0] act_a;
        logic [LW-1:0] act_l;
        logic          pnd_v;
        logic [AW-1:0] pnd_a;
        logic [LW-1:0] pnd_l;
    } slot_t;

    slot_t q, d;
    logic accept, commit;

    always_comb begin
        d        = q;
        room     = !(q.act_v && q.pnd_v);
        ovr_evt  = wr_en && !room;
        accept   = wr_en && room;
        commit   = accept && wr_sel && (wr_data[LW-1:0] != '0);
        if (accept && !wr_sel) begin
            d.stage_addr = wr_data;
        end
        if (frame_end) begin
            d.act_v = q.pnd_v;
            d.act_a = q.pnd_a;
            d.act_l = q.pnd_l;
            d.pnd_v = 1'b0;
        end
        if (commit) begin
            if (!d.act_v) begin
                d.act_v = 1'b1;
                d.act_a = q.stage_addr;
                d.act_l = wr_data[LW-1:0];
            end else begin
                d.pnd_v = 1'b1;
                d.pnd_a = q.stage_addr;
                d.pnd_l = wr_data[LW-1:0];
            end
        end
        idle_evt = frame_end && !q.pnd_v && !commit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign act_valid = q.act_v;
    assign act_addr  = q.act_a;
    assign act_len   = q.act_l;

    // R4
    overrun_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_evt && !frame_end) |=> ($stable(q.act_a) && $stable(q.act_l) &&
            $stable(q.pnd_a) && $stable(q.pnd_l) && $stable(q.stage_addr)));
    // R5
    promote_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_end && q.pnd_v) |=> (q.act_v && q.act_a == $past(q.pnd_a)));
    // R3
    pend_needs_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.pnd_v |-> q.act_v);
endmodule

// File: rtl/tx_byte_engine.sv
module tx_byte_engine #(
    parameter int AW = 32,
    parameter int LW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          act_valid,
    input  logic [AW-1:0] act_addr,
    input  logic [LW-1:0] act_len,
    input  logic          fetch_ready,
    input  logic [7:0]    fetch_data,
    output logic          fetch_rd,
    output logic [AW-1:0] fetch_addr,
    output logic          frame_done,
    output logic          frame_abort,
    output logic          tx_valid,
    output logic [7:0]    tx_byte,
    output logic          tx_last,
    output logic          tx_bad_crc
);
    typedef struct packed {
        logic [LW-1:0] idx;
        logic          vld;
        logic [7:0]    dat;
        logic          lst;
        logic          bad;
    } eng_t;

    eng_t q, d;
    logic last_byte;

    always_comb begin
        d           = q;
        d.vld       = 1'b0;
        d.lst       = 1'b0;
        d.bad       = 1'b0;
        frame_done  = 1'b0;
        frame_abort = 1'b0;
        fetch_rd    = act_valid;
        fetch_addr  = act_addr + AW'(q.idx);
        last_byte   = (q.idx == act_len - LW'(1));
        if (act_valid) begin
            if (fetch_ready) begin
                d.vld = 1'b1;
                d.dat = fetch_data;
                d.lst = last_byte;
                if (last_byte) begin
                    d.idx      = '0;
                    frame_done = 1'b1;
                end else begin
                    d.idx = q.idx + LW'(1);
                end
            end else begin
                d.lst       = 1'b1;
                d.bad       = 1'b1;
                d.idx       = '0;
                frame_abort = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign tx_valid   = q.vld;
    assign tx_byte    = q.dat;
    assign tx_last    = q.lst;
    assign tx_bad_crc = q.bad;

    // R7
    abort_marker_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act_valid && !fetch_ready) |=> (tx_last && tx_bad_crc && !tx_valid));
    // R7
    bad_only_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_bad_crc |-> (tx_last && !tx_valid));
endmodule

// File: rtl/tx_status_flags.sv
module tx_status_flags
    import tx_slot_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             room,
    input  logic             busy,
    input  logic             ovr_evt,
    input  logic             idle_evt,
    input  logic             done_evt,
    input  logic             abort_evt,
    input  logic             clr_wr,
    input  logic [STS_W-1:0] clr_data,
    output logic [STS_W-1:0] status
);
    logic [STS_W-1:0] stky_q, stky_d, set_vec, clr_vec;

    always_comb begin
        set_vec          = '0;
        set_vec[ST_OVR]  = ovr_evt;
        set_vec[ST_IDLE] = idle_evt;
        set_vec[ST_CMPL] = done_evt;
        set_vec[ST_UNDR] = abort_evt;
        clr_vec          = clr_wr ? clr_data : '0;
        stky_d           = ((stky_q & ~clr_vec) | set_vec) & STICKY_MASK;
        status           = stky_q;
        status[ST_ROOM]  = room;
        status[ST_BUSY]  = busy;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stky_q <= '0;
        else        stky_q <= stky_d;
    end

    // R6
    cmpl_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_evt |=> status[ST_CMPL]);
    // R9
    set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_evt && clr_wr && clr_data[ST_OVR]) |=> status[ST_OVR]);
    // R7
    undr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort_evt |=> status[ST_UNDR]);
endmodule

// File: rtl/tx_slot_ctrl.sv
module tx_slot_ctrl
    import tx_slot_pkg::*;
#(
    parameter int AW = 32,
    parameter int LW = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr_en,
    input  logic             reg_wr_sel,
    input  logic [AW-1:0]    reg_wr_data,
    input  logic             sts_clr_wr,
    input  logic [STS_W-1:0] sts_clr_data,
    output logic [STS_W-1:0] sts_flags,
    output logic             fetch_rd,
    output logic [AW-1:0]    fetch_addr,
    input  logic [7:0]       fetch_data,
    input  logic             fetch_ready,
    output logic             tx_valid,
    output logic [7:0]       tx_byte,
    output logic             tx_last,
    output logic             tx_bad_crc
);
    logic          act_valid, room, ovr_evt, idle_evt;
    logic [AW-1:0] act_addr;
    logic [LW-1:0] act_len;
    logic          frame_done, frame_abort, frame_end;

    assign frame_end = frame_done || frame_abort;

    tx_slot_queue #(.AW(AW), .LW(LW)) u_queue (
        .clk(clk), .rst_n(rst_n),
        .wr_en(reg_wr_en), .wr_sel(reg_wr_sel), .wr_data(reg_wr_data),
        .frame_end(frame_end),
        .act_valid(act_valid), .act_addr(act_addr), .act_len(act_len),
        .room(room), .ovr_evt(ovr_evt), .idle_evt(idle_evt)
    );

    tx_byte_engine #(.AW(AW), .LW(LW)) u_engine (
        .clk(clk), .rst_n(rst_n),
        .act_valid(act_valid), .act_addr(act_addr), .act_len(act_len),
        .fetch_ready(fetch_ready), .fetch_data(fetch_data),
        .fetch_rd(fetch_rd), .fetch_addr(fetch_addr),
        .frame_done(frame_done), .frame_abort(frame_abort),
        .tx_valid(tx_valid), .tx_byte(tx_byte), .tx_last(tx_last),
        .tx_bad_crc(tx_bad_crc)
    );

    tx_status_flags u_flags (
        .clk(clk), .rst_n(rst_n),
        .room(room), .busy(act_valid),
        .ovr_evt(ovr_evt), .idle_evt(idle_evt),
        .done_evt(frame_done), .abort_evt(frame_abort),
        .clr_wr(sts_clr_wr), .clr_data(sts_clr_data),
        .status(sts_flags)
    );

    // R3
    full_blocks_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sts_flags[ST_ROOM]) |-> sts_flags[ST_BUSY]);
endmodule

// File: tb/sim_tx_slot_ctrl.sv
module sim_tx_slot_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0, reg_wr_sel = 1'b0;
    logic [31:0] reg_wr_data = '0;
    logic        sts_clr_wr = 1'b0;
    logic [6:0]  sts_clr_data = '0;
    logic [6:0]  sts_flags;
    logic        fetch_rd, fetch_ready = 1'b1;
    logic [31:0] fetch_addr;
    logic [7:0]  fetch_data, tx_byte;
    logic        tx_valid, tx_last, tx_bad_crc;

    always #5 clk = ~clk;

    assign fetch_data = fetch_addr[7:0] + 8'h3C;

    tx_slot_ctrl u0 (
        .clk(clk), .rst_n(rst_n),
        .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel), .reg_wr_data(reg_wr_data),
        .sts_clr_wr(sts_clr_wr), .sts_clr_data(sts_clr_data), .sts_flags(sts_flags),
        .fetch_rd(fetch_rd), .fetch_addr(fetch_addr), .fetch_data(fetch_data),
        .fetch_ready(fetch_ready),
        .tx_valid(tx_valid), .tx_byte(tx_byte), .tx_last(tx_last), .tx_bad_crc(tx_bad_crc)
    );

    int n_chk = 0, n_err = 0, cyc = 0;
    bit done = 1'b0;
    logic [7:0] bb [0:255];
    int bcy [0:255];
    int bcnt = 0, fcnt = 0, cur = 0;
    int fn [0:31];
    bit fb [0:31];

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (tx_valid) begin
            bb[bcnt] = tx_byte; bcy[bcnt] = cyc; bcnt = bcnt + 1; cur = cur + 1;
        end
        if (tx_last) begin
            fn[fcnt] = cur; fb[fcnt] = tx_bad_crc; fcnt = fcnt + 1; cur = 0;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input bit sel, input logic [31:0] dat);
        reg_wr_en = 1'b1; reg_wr_sel = sel; reg_wr_data = dat;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic clr(input logic [6:0] m);
        sts_clr_wr = 1'b1; sts_clr_data = m;
        @(negedge clk);
        sts_clr_wr = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 100 && sts_flags[1]; i++) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic chk_frame(input int b0, input int f, input int addr, input int len,
                             input bit bad, input string req);
        chk(fn[f] == len, req, fn[f], len);
        chk(fb[f] == bad, req, int'(fb[f]), int'(bad));
        for (int i = 0; i < len; i++) begin
            logic [7:0] e;
            e = 8'(addr + i) + 8'h3C;
            chk(bb[b0 + i] == e, req, bb[b0 + i], e);
        end
    endtask

    task automatic t_reset();
        // R1
        chk(sts_flags == 7'h01, "R1 status", sts_flags, 7'h01);
        chk({tx_valid, tx_last, tx_bad_crc, fetch_rd} == 4'b0, "R1 outputs",
            {tx_valid, tx_last, tx_bad_crc, fetch_rd}, 0);
    endtask

    task automatic t_single();
        int b0, f0;
        b0 = bcnt; f0 = fcnt;
        @(negedge clk);
        wr(0, 32'h100);
        wr(1, 32'd4);
        chk(sts_flags[1] == 1'b1, "R3 busy", sts_flags, 7'h03);
        wait_idle();
        // R2 R6 R8
        chk(fcnt - f0 == 1, "R2 frame count", fcnt - f0, 1);
        chk_frame(b0, f0, 32'h100, 4, 1'b0, "R2 bytes");
        chk(sts_flags == 7'h29, "R6 R8 status", sts_flags, 7'h29);
        clr(7'h7F);
        // R9
        chk(sts_flags == 7'h01, "R9 clear", sts_flags, 7'h01);
    endtask

    task automatic t_double();
        int b0, f0;
        b0 = bcnt; f0 = fcnt;
        @(negedge clk);
        wr(0, 32'h200);
        wr(1, 32'd8);
        wr(0, 32'h300);
        wr(1, 32'd2);
        // R3
        chk(sts_flags[1:0] == 2'b10, "R3 full", sts_flags, 7'h02);
        reg_wr_en = 1'b1; reg_wr_sel = 1'b1; reg_wr_data = 32'd5;
        sts_clr_wr = 1'b1; sts_clr_data = 7'h04;
        @(negedge clk);
        reg_wr_en = 1'b0; sts_clr_wr = 1'b0;
        // R4 R9 set wins
        chk(sts_flags[2] == 1'b1, "R9 set wins", sts_flags, 7'h04);
        clr(7'h04);
        chk(sts_flags[2] == 1'b0, "R9 clear ovr", sts_flags, 0);
        wr(0, 32'h777);
        chk(sts_flags[2] == 1'b1, "R4 addr overrun", sts_flags, 7'h04);
        wait_idle();
        // R4 R5
        chk(fcnt - f0 == 2, "R4 frame count", fcnt - f0, 2);
        chk_frame(b0, f0, 32'h200, 8, 1'b0, "R5 first");
        chk_frame(b0 + 8, f0 + 1, 32'h300, 2, 1'b0, "R4 pending intact");
        chk(bcy[b0 + 8] == bcy[b0 + 7] + 1, "R5 no gap", bcy[b0 + 8] - bcy[b0 + 7], 1);
        clr(7'h7F);
    endtask

    task automatic t_coincide();
        int b0, f0;
        b0 = bcnt; f0 = fcnt;
        @(negedge clk);
        wr(0, 32'h400);
        wr(1, 32'd3);
        wr(0, 32'h500);
        @(negedge clk);
        wr(1, 32'd4);
        // R8 commit in same cycle as frame end
        chk(sts_flags[3] == 1'b0, "R8 idle held", sts_flags, 0);
        chk(sts_flags[1] == 1'b1, "R3 busy", sts_flags, 7'h02);
        wait_idle();
        chk(fcnt - f0 == 2, "R2 frame count", fcnt - f0, 2);
        chk_frame(b0, f0, 32'h400, 3, 1'b0, "R2 first");
        chk_frame(b0 + 3, f0 + 1, 32'h500, 4, 1'b0, "R2 second");
        chk(bcy[b0 + 3] == bcy[b0 + 2] + 1, "R5 direct start", bcy[b0 + 3] - bcy[b0 + 2], 1);
        chk(sts_flags == 7'h29, "R8 final", sts_flags, 7'h29);
        clr(7'h7F);
    endtask

    task automatic t_underrun();
        int b0, f0;
        b0 = bcnt; f0 = fcnt;
        @(negedge clk);
        wr(0, 32'h600);
        wr(1, 32'd6);
        @(negedge clk);
        @(negedge clk);
        fetch_ready = 1'b0;
        @(negedge clk);
        fetch_ready = 1'b1;
        wait_idle();
        // R7
        chk(fcnt - f0 == 1, "R7 frame count", fcnt - f0, 1);
        chk_frame(b0, f0, 32'h600, 2, 1'b1, "R7 aborted");
        chk(sts_flags == 7'h49, "R7 status", sts_flags, 7'h49);
        clr(7'h7F);
        b0 = bcnt; f0 = fcnt;
        wr(0, 32'h610);
        wr(1, 32'd2);
        wait_idle();
        chk_frame(b0, f0, 32'h610, 2, 1'b0, "R7 recovery");
        clr(7'h7F);
    endtask

    task automatic t_quiet();
        int b0;
        b0 = bcnt;
        @(negedge clk);
        wr(0, 32'h700);
        repeat (5) @(negedge clk);
        // R2
        chk(bcnt == b0 && sts_flags == 7'h01, "R2 address only", sts_flags, 7'h01);
        wr(1, 32'd0);
        repeat (5) @(negedge clk);
        // R10
        chk(bcnt == b0 && sts_flags == 7'h01, "R10 zero length", sts_flags, 7'h01);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single();
        t_double();
        t_coincide();
        t_underrun();
        t_quiet();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
            $finish;
        end
    end
endmodule